// File: doc/BRIEF.md
# Command List Control Register Block

This block is the software-visible control surface of a command-list engine. A host sets up a list by writing a base pointer and then a limit pointer over a simple word-addressed bus. Writing the base also sets the running cursor to that value. Writing the limit may start the engine: a one-cycle `kick` pulse goes out only when the new limit lies strictly above the stored base. A limit equal to the base is an empty list and is ignored. A limit below the base is refused and raises a range error.

Three mode flags (external-source select, hold, drain) are never written directly. Each has a clear bit and a set bit in the status write word, so software can change one flag without a read-modify-write. A read-only word returns a free-running cycle count that arrives on an input port. Every other offset reads as zero. Reads are combinational. Writes take effect at the clock edge on which `bus_sel` and `bus_we` are both high.

Top module: `cmdlist_regs`

## Requirements
- R1: After reset, the base, limit, cursor, status word, `kick`, `range_err` and all three flag outputs are zero.
- R2: A write to byte offset 0x00 stores the base. The same edge loads the cursor (offset 0x08) with the written value.
- R3: A write to offset 0x04 stores the limit. When the written value is unsigned-greater than the stored base, `kick` is high for exactly the one cycle after the write edge.
- R4: A limit write equal to the stored base gives no `kick` and no range error.
- R5: A limit write below the stored base (unsigned) gives no `kick`. It sets `range_err`, which is also status read bit 3. The next limit write that is not below the base clears it.
- R6: In a status write (offset 0x0C), bit 0 clears and bit 1 sets the external-source flag. The flag is output `src_ext` and status read bit 0.
- R7: In a status write, bit 2 clears and bit 3 sets the hold flag. The flag is output `hold` and status read bit 1.
- R8: In a status write, bit 4 clears and bit 5 sets the drain flag. The flag is output `drain` and status read bit 2.
- R9: A flag whose clear and set bits are both 1 in one status write keeps its value. A flag whose clear and set bits are both 0 also keeps its value.
- R10: Offset 0x10 reads the value on `clk_count`. Writes to offsets 0x08 and 0x10 change no stored state.
- R11: Offsets 0x14 to 0x1C, and any offset whose two low bits are not zero, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| clk_count | input | DATA_W | External cycle count, returned at offset 0x10 |
| kick | output | 1 | One-cycle start pulse for the list engine |
| range_err | output | 1 | Last limit write was below the base |
| src_ext | output | 1 | External-source flag |
| hold | output | 1 | Hold flag |
| drain | output | 1 | Drain flag |

## Verification
Two effects can land on a single edge. The clear and set bits of one flag pair can arrive in the same status write. A limit write can also be compared against a base that was written on the edge just before it. The bench applies all 64 status control words from each of the 8 starting flag states and reads back the status word and flag outputs. The expected values come from a per-pair rule model. For the ranges, the bench writes the base and then the limit back to back for every pair taken from a set of corner values (0, 1, 7, midpoint, all ones). It judges `kick` in the cycle after the write and again one cycle later, and judges `range_err` against the unsigned ordering.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;
    // word index of each mapped register (byte offset = index * 4)
    localparam int unsigned IDX_BASE   = 0;
    localparam int unsigned IDX_LIMIT  = 1;
    localparam int unsigned IDX_CURSOR = 2;
    localparam int unsigned IDX_STATUS = 3;
    localparam int unsigned IDX_CYCLES = 4;

    localparam int unsigned NUM_FLAGS  = 3;

    // flag order inside the flag vector and the status read word
    localparam int unsigned FLG_SRC   = 0;
    localparam int unsigned FLG_HOLD  = 1;
    localparam int unsigned FLG_DRAIN = 2;
    localparam int unsigned ERR_BIT   = NUM_FLAGS;

    typedef enum logic [2:0] {
        SEL_BASE,
        SEL_LIMIT,
        SEL_CURSOR,
        SEL_STATUS,
        SEL_CYCLES,
        SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/cmdl_addr_decode.sv
module cmdl_addr_decode
    import cmdl_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            if (widx == WIDX_W'(IDX_BASE))        sel = SEL_BASE;
            else if (widx == WIDX_W'(IDX_LIMIT))  sel = SEL_LIMIT;
            else if (widx == WIDX_W'(IDX_CURSOR)) sel = SEL_CURSOR;
            else if (widx == WIDX_W'(IDX_STATUS)) sel = SEL_STATUS;
            else if (widx == WIDX_W'(IDX_CYCLES)) sel = SEL_CYCLES;
            else                                  sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/cmdl_flag_pairs.sv
module cmdl_flag_pairs #(
    parameter int unsigned NFLAG = 3
) (
    input  logic               wr_en,
    input  logic [2*NFLAG-1:0] ctrl,
    input  logic [NFLAG-1:0]   flags_q,
    output logic [NFLAG-1:0]   flags_d
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_pair
        logic clr_bit;
        logic set_bit;

        assign clr_bit = ctrl[2*i];
        assign set_bit = ctrl[2*i+1];

        always_comb begin
            flags_d[i] = flags_q[i];
            if (wr_en) begin
                case ({set_bit, clr_bit})
                    2'b10:   flags_d[i] = 1'b1;
                    2'b01:   flags_d[i] = 1'b0;
                    default: flags_d[i] = flags_q[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/cmdl_span_check.sv
module cmdl_span_check #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] limit,
    output logic              nonempty,
    output logic              inverted
);
    always_comb begin
        nonempty = (limit > base);
        inverted = (limit < base);
    end
endmodule

// File: rtl/cmdlist_regs.sv
module cmdlist_regs
    import cmdl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] clk_count,
    output logic              kick,
    output logic              range_err,
    output logic              src_ext,
    output logic              hold,
    output logic              drain
);
    localparam int unsigned CTRL_W = 2 * NUM_FLAGS;

    typedef struct packed {
        logic [DATA_W-1:0]    base;
        logic [DATA_W-1:0]    limit;
        logic [DATA_W-1:0]    cursor;
        logic [NUM_FLAGS-1:0] flags;
        logic                 err;
        logic                 kick;
    } state_t;

    state_t st_q;
    state_t st_d;

    reg_sel_e             sel;
    logic                 wr;
    logic [NUM_FLAGS-1:0] flags_d;
    logic                 span_nonempty;
    logic                 span_inverted;

    // observation points for the bound checker
    logic [DATA_W-1:0]    base_q;
    logic [DATA_W-1:0]    cursor_q;
    logic [NUM_FLAGS-1:0] flags_q;

    assign wr = bus_sel && bus_we;

    cmdl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    cmdl_flag_pairs #(.NFLAG(NUM_FLAGS)) u_flags (
        .wr_en   (wr && (sel == SEL_STATUS)),
        .ctrl    (bus_wdata[CTRL_W-1:0]),
        .flags_q (st_q.flags),
        .flags_d (flags_d)
    );

    cmdl_span_check #(.DATA_W(DATA_W)) u_span (
        .base     (st_q.base),
        .limit    (bus_wdata),
        .nonempty (span_nonempty),
        .inverted (span_inverted)
    );

    always_comb begin
        st_d       = st_q;
        st_d.kick  = 1'b0;
        st_d.flags = flags_d;
        if (wr) begin
            case (sel)
                SEL_BASE: begin
                    st_d.base   = bus_wdata;
                    st_d.cursor = bus_wdata;
                end
                SEL_LIMIT: begin
                    st_d.limit = bus_wdata;
                    st_d.kick  = span_nonempty;
                    st_d.err   = span_inverted;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_BASE:   bus_rdata = st_q.base;
            SEL_LIMIT:  bus_rdata = st_q.limit;
            SEL_CURSOR: bus_rdata = st_q.cursor;
            SEL_STATUS: begin
                bus_rdata[NUM_FLAGS-1:0] = st_q.flags;
                bus_rdata[ERR_BIT]       = st_q.err;
            end
            SEL_CYCLES: bus_rdata = clk_count;
            default:    bus_rdata = '0;
        endcase
    end

    assign kick      = st_q.kick;
    assign range_err = st_q.err;
    assign src_ext   = st_q.flags[FLG_SRC];
    assign hold      = st_q.flags[FLG_HOLD];
    assign drain     = st_q.flags[FLG_DRAIN];
    assign base_q    = st_q.base;
    assign cursor_q  = st_q.cursor;
    assign flags_q   = st_q.flags;
endmodule

// File: rtl/cmdl_regs_chk.sv
module cmdl_regs_chk
    import cmdl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [DATA_W-1:0]    clk_count,
    input logic                 kick,
    input logic                 range_err,
    input logic [DATA_W-1:0]    base_q,
    input logic [DATA_W-1:0]    cursor_q,
    input logic [NUM_FLAGS-1:0] flags_q
);
    localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(4 * IDX_BASE);
    localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(4 * IDX_LIMIT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(4 * IDX_STATUS);
    localparam logic [ADDR_W-1:0] A_CYCLES = ADDR_W'(4 * IDX_CYCLES);

    logic wr;
    assign wr = bus_sel && bus_we;

    AST_BASE_LOADS_CURSOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_BASE) |=> (cursor_q == $past(bus_wdata) && base_q == $past(bus_wdata))); // R2
    AST_KICK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> $past(wr && bus_addr == A_LIMIT && bus_wdata > base_q)); // R3
    AST_EMPTY_NO_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_LIMIT && bus_wdata == base_q) |=> (!kick && !range_err)); // R4
    AST_INVERTED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_LIMIT && bus_wdata < base_q) |=> (range_err && !kick)); // R5
    AST_PAIR_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_STATUS && bus_wdata[1:0] == 2'b11) |=> $stable(flags_q[FLG_SRC])); // R9
    AST_CYCLES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CYCLES) |-> (bus_rdata == clk_count)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00 || bus_addr > A_CYCLES) |-> (bus_rdata == '0)); // R11
endmodule

bind cmdlist_regs cmdl_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_count (clk_count),
    .kick      (kick),
    .range_err (range_err),
    .base_q    (base_q),
    .cursor_q  (cursor_q),
    .flags_q   (flags_q)
);

// File: tb/sim_cmdlist_regs.sv
`timescale 1ns/1ps
module sim_cmdlist_regs;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] clk_count = '0;
    logic          kick, range_err, src_ext, hold, drain;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic kick_after;

    always #2.5 clk = ~clk;

    cmdlist_regs #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_count(clk_count), .kick(kick), .range_err(range_err),
        .src_ext(src_ext), .hold(hold), .drain(drain)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write; kick_after holds kick sampled just after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 kick_after = kick;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [DW-1:0] corner [5];
        corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'h7;
        corner[3] = 32'h8000_0000; corner[4] = 32'hFFFF_FFFF;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(AW'(4*a), r);
            check("R1 reg after reset", r, '0);
        end
        check("R1 outputs after reset", {27'd0, kick, range_err, src_ext, hold, drain}, '0);

        // R2 base write loads cursor
        wr(5'h00, 32'h1234_5678);
        rd(5'h00, r); check("R2 base", r, 32'h1234_5678);
        rd(5'h08, r); check("R2 cursor copy", r, 32'h1234_5678);

        // R10 writes to cursor and cycle count ignored
        wr(5'h08, 32'hDEAD_BEEF);
        rd(5'h08, r); check("R10 cursor write ignored", r, 32'h1234_5678);
        wr(5'h10, 32'hCAFE_0000);
        clk_count = 32'h0BAD_F00D;
        rd(5'h10, r); check("R10 cycle count read", r, 32'h0BAD_F00D);
        rd(5'h00, r); check("R10 base unchanged", r, 32'h1234_5678);
        rd(5'h04, r); check("R10 limit unchanged", r, 32'h0);

        // R3 R4 R5 base/limit corner sweep
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                logic ek, ee;
                ek = corner[j] > corner[i];
                ee = corner[j] < corner[i];
                wr(5'h00, corner[i]);
                wr(5'h04, corner[j]);
                if (corner[j] == corner[i]) begin
                    check("R4 equal no kick", {31'd0, kick_after}, 32'd0);
                    check("R4 equal no error", {31'd0, range_err}, 32'd0);
                end else if (ee) begin
                    check("R5 inverted no kick", {31'd0, kick_after}, 32'd0);
                    check("R5 inverted err", {31'd0, range_err}, 32'd1);
                    rd(5'h0C, r);
                    check("R5 err status bit3", {31'd0, r[3]}, 32'd1);
                end else begin
                    check("R3 kick after limit write", {31'd0, kick_after}, {31'd0, ek});
                    check("R5 err cleared", {31'd0, range_err}, 32'd0);
                end
                @(posedge clk); #1;
                check("R3 kick one cycle only", {31'd0, kick}, 32'd0);
                rd(5'h04, r); check("R3 limit stored", r, corner[j]);
            end
        end
        wr(5'h00, 32'h0); wr(5'h04, 32'h0); // leave err clear

        // R6 R7 R8 R9 exhaustive status control sweep
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 64; c++) begin
                logic [2:0] exp;
                logic [5:0] init_ctrl;
                for (int p = 0; p < 3; p++) init_ctrl[2*p +: 2] = s[p] ? 2'b10 : 2'b01;
                wr(5'h0C, {26'd0, init_ctrl});
                wr(5'h0C, 32'(c));
                for (int p = 0; p < 3; p++) begin
                    logic cl, se;
                    cl = c[2*p]; se = c[2*p+1];
                    if (se && !cl)      exp[p] = 1'b1;
                    else if (cl && !se) exp[p] = 1'b0;
                    else                exp[p] = s[p]; // R9 keep
                end
                rd(5'h0C, r);
                check("R6 R7 R8 R9 status word", r, {29'd0, exp});
                check("R6 src_ext pin", {31'd0, src_ext}, {31'd0, exp[0]});
                check("R7 hold pin", {31'd0, hold}, {31'd0, exp[1]});
                check("R8 drain pin", {31'd0, drain}, {31'd0, exp[2]});
            end
        end

        // R11 unmapped / misaligned reads
        for (int a = 0; a < 32; a++) begin
            if ((a % 4) != 0 || a > 16) begin
                rd(AW'(a), r);
                check("R11 unmapped reads zero", r, '0);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule